// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the phase sequence of a single programmed-I/O transfer on an IDE-style disk bus: an address setup phase with chip-select asserted, an active phase in which the read or write strobe is asserted, and a recovery phase in which the bus is idle. It serves four drives on two channels. Drives 0 and 1 sit on the primary channel and drives 2 and 3 on the secondary channel.

A byte-wide host register port holds the timing state. Each timing set has a setup byte, whose top two bits code the setup length, and a strobe byte, which packs the active and recovery lengths as nibbles. Drive 0 and drive 1 each have their own set. The two secondary drives share a single set. A command-block timing byte governs accesses flagged as command accesses. A configuration byte carries a silicon revision code, and later revisions lengthen recovery by one clock.

A request carries a drive index, a command-or-data flag and a direction. The block accepts it only while idle. The block captures that drive's timing at the moment of acceptance, runs the three phases, and pulses `done` in the last recovery clock.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `cs`=0, both strobes 0, `done`=0. Every register reads 0x00 except the configuration byte, which reads the reset revision (default 1). The resulting timing is 4 setup, 16 active and 16 recovery clocks.
- R2: Setup length comes from bits 7:6 of the drive's setup byte: code 00 gives 4 clocks, 10 gives 3, 01 gives 2 and 11 gives 5. During setup, `cs` is asserted and neither strobe is asserted.
- R3: A write with `reg_setup_only`=1 to a setup byte changes only bits 7:6 and keeps bits 5:0. The same write to any other address changes nothing.
- R4: Active length is the upper nibble of the strobe byte. Value 0 gives 16 clocks, and value 1 behaves as 2 clocks. The active phase is never shorter than 2 clocks.
- R5: Recovery length is the lower nibble of the strobe byte, with 0 giving 16. When the revision field (configuration bits 1:0) exceeds 1, recovery lasts one clock more.
- R6: Register map: 0 is configuration, 1 is command timing, 2/3 are the drive 0 setup/strobe bytes, 4/5 are the drive 1 bytes, and 6/7 are the bytes shared by drives 2 and 3. `cs[0]` serves drives 0 and 1, and `cs[1]` serves drives 2 and 3. At most one bit of `cs` is set.
- R7: For a command access, a command timing byte of 0 selects 4 setup, 16 active and 16 recovery clocks (plus the revision extra). A nonzero byte supplies the active and recovery nibbles by the R4 and R5 rules, and the setup length still comes from the drive's setup byte.
- R8: Phases run setup, then active, then recovery, then idle. `rd_strobe` (read) or `wr_strobe` (write) is asserted only in the active phase, and never both at once. `cs` is low in recovery. `done` is high for exactly one clock, the last recovery clock. `req_ready` is high only in idle, and requests that arrive while busy are ignored.
- R9: A register write during a cycle leaves that cycle's timing unchanged and applies from the next accepted request.
- R10: Every register reads back the value last written to it. The configuration byte returns only bits 1:0, with the rest read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_setup_only | input | 1 | Restrict a write to setup-code bits 7:6 of a setup byte |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Transfer request |
| req_drive | input | 2 | Drive index 0..3 |
| req_cmd | input | 1 | 1 = command-block access, 0 = data access |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_ready | output | 1 | Idle, a request is accepted this clock |
| cs | output | 2 | Per-channel chip-select, active high |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| done | output | 1 | One-clock pulse in the final recovery clock |

## Verification
A wrong latched count or a wrong decode shows up within one transfer, as a setup, active or recovery phase that is too long or too short at the `cs` and strobe pins. The bench therefore measures every phase length of every transfer. A sequencer that leaves a phase early or loses its state shows up as a `done` that is missing or doubled, as a strobe outside `cs`, or as a `req_ready` that does not return in the clock after `done`. A wrong register index shows up as one drive taking another drive's timing on its next transfer. A missed write-during-cycle isolation shows up as the current transfer's lengths changing part-way through.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

   localparam int TCNT_W = 5;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [TCNT_W-1:0] setup;
      logic [TCNT_W-1:0] active;
      logic [TCNT_W-1:0] recov;
   } tmg_t;

   function automatic logic [TCNT_W-1:0] setup_clocks(input logic [1:0] code);
      logic [TCNT_W-1:0] r;
      case (code)
         2'b00:   r = TCNT_W'(4);
         2'b10:   r = TCNT_W'(3);
         2'b01:   r = TCNT_W'(2);
         default: r = TCNT_W'(5);
      endcase
      return r;
   endfunction

   function automatic logic [TCNT_W-1:0] nib_clocks(input logic [3:0] n);
      return (n == 4'd0) ? TCNT_W'(16) : {{(TCNT_W-4){1'b0}}, n};
   endfunction

   function automatic logic [TCNT_W-1:0] active_clocks(input logic [3:0] n);
      return (n == 4'd1) ? TCNT_W'(2) : nib_clocks(n);
   endfunction

endpackage

// File: rtl/pio_tmg_regs.sv
module pio_tmg_regs
   import pio_tmg_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int NUM_SETS  = 3,
   parameter int RESET_REV = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic                       setup_only,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [BYTE_W-1:0]          wdata,
   output logic [BYTE_W-1:0]          rdata,
   output logic [1:0]                 cfg_rev,
   output logic [BYTE_W-1:0]          cmd_tmg,
   output logic [NUM_SETS*BYTE_W-1:0] addr_tmg,
   output logic [NUM_SETS*BYTE_W-1:0] rw_tmg
);

   localparam int A_CFG   = 0;
   localparam int A_CMD   = 1;
   localparam int A_BASE  = 2;
   localparam int A_LAST  = A_BASE + 2*NUM_SETS - 1;

   if (A_LAST >= (1 << ADDR_W)) begin : g_bad_map
      $error("register map does not fit in ADDR_W");
   end
   if (RESET_REV < 0 || RESET_REV > 3) begin : g_bad_rev
      $error("RESET_REV must fit two bits");
   end

   logic [1:0]        rev_q;
   logic [BYTE_W-1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rev_q <= 2'(RESET_REV);
         cmd_q <= '0;
      end else if (we && !setup_only) begin
         if (int'(addr) == A_CFG) rev_q <= wdata[1:0];
         if (int'(addr) == A_CMD) cmd_q <= wdata;
      end
   end

   for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
      localparam int A_SU = A_BASE + 2*k;
      localparam int A_RW = A_BASE + 2*k + 1;
      logic [BYTE_W-1:0] su_q;
      logic [BYTE_W-1:0] rw_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            su_q <= '0;
            rw_q <= '0;
         end else if (we) begin
            if (int'(addr) == A_SU) begin
               if (setup_only) su_q <= {wdata[7:6], su_q[5:0]};
               else            su_q <= wdata;
            end
            if (int'(addr) == A_RW && !setup_only) rw_q <= wdata;
         end
      end

      assign addr_tmg[k*BYTE_W +: BYTE_W] = su_q;
      assign rw_tmg[k*BYTE_W +: BYTE_W]   = rw_q;
   end

   always_comb begin
      rdata = '0;
      if (int'(addr) == A_CFG) rdata = {6'd0, rev_q};
      if (int'(addr) == A_CMD) rdata = cmd_q;
      for (int k = 0; k < NUM_SETS; k++) begin
         if (int'(addr) == A_BASE + 2*k)     rdata = addr_tmg[k*BYTE_W +: BYTE_W];
         if (int'(addr) == A_BASE + 2*k + 1) rdata = rw_tmg[k*BYTE_W +: BYTE_W];
      end
   end

   assign cfg_rev = rev_q;
   assign cmd_tmg = cmd_q;

endmodule

// File: rtl/pio_tmg_resolve.sv
module pio_tmg_resolve
   import pio_tmg_pkg::*;
#(
   parameter int NUM_SETS  = 3,
   parameter bit REV_EXTRA = 1'b1
) (
   input  logic [1:0]                 drive,
   input  logic                       is_cmd,
   input  logic [1:0]                 cfg_rev,
   input  logic [BYTE_W-1:0]          cmd_tmg,
   input  logic [NUM_SETS*BYTE_W-1:0] addr_tmg,
   input  logic [NUM_SETS*BYTE_W-1:0] rw_tmg,
   output tmg_t                       tmg
);

   if (NUM_SETS != 3) begin : g_bad_sets
      $error("two private sets plus one shared secondary set are required");
   end

   logic [1:0]        set_idx;
   logic [BYTE_W-1:0] su_byte;
   logic [BYTE_W-1:0] rw_byte;
   logic [BYTE_W-1:0] strobe_byte;
   logic              extra;

   // secondary channel drives map onto the last, shared set
   assign set_idx = drive[1] ? 2'(NUM_SETS-1) : {1'b0, drive[0]};
   assign su_byte = addr_tmg[set_idx*BYTE_W +: BYTE_W];
   assign rw_byte = rw_tmg[set_idx*BYTE_W +: BYTE_W];

   // a zero command byte means slowest (both nibbles 0 -> 16)
   assign strobe_byte = is_cmd ? cmd_tmg : rw_byte;

   if (REV_EXTRA) begin : g_rev_extra
      assign extra = (cfg_rev > 2'd1);
   end else begin : g_rev_flat
      assign extra = 1'b0;
   end

   always_comb begin
      if (is_cmd && cmd_tmg == '0) tmg.setup = TCNT_W'(4);
      else                         tmg.setup = setup_clocks(su_byte[7:6]);
      tmg.active = active_clocks(strobe_byte[7:4]);
      tmg.recov  = nib_clocks(strobe_byte[3:0]) + {{(TCNT_W-1){1'b0}}, extra};
   end

endmodule

// File: rtl/pio_tmg_seq.sv
module pio_tmg_seq
   import pio_tmg_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [$clog2(NUM_CH)-1:0] req_chan,
   input  logic              req_write,
   input  tmg_t              tmg,
   output logic              ready,
   output logic [NUM_CH-1:0] cs,
   output logic              rd_strobe,
   output logic              wr_strobe,
   output logic              done
);

   localparam int CH_W = $clog2(NUM_CH);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("at least two channels are expected");
   end

   phase_e            ph_q;
   logic [TCNT_W-1:0] cnt_q;
   logic [TCNT_W-1:0] act_q;
   logic [TCNT_W-1:0] rec_q;
   logic [CH_W-1:0]   chan_q;
   logic              wr_q;
   logic              last;

   assign last = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         act_q  <= '0;
         rec_q  <= '0;
         chan_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (req_valid) begin
                  ph_q   <= PH_SETUP;
                  cnt_q  <= tmg.setup - TCNT_W'(1);
                  act_q  <= tmg.active;
                  rec_q  <= tmg.recov;
                  chan_q <= req_chan;
                  wr_q   <= req_write;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  ph_q  <= PH_ACTIVE;
                  cnt_q <= act_q - TCNT_W'(1);
               end else begin
                  cnt_q <= cnt_q - TCNT_W'(1);
               end
            end
            PH_ACTIVE: begin
               if (last) begin
                  ph_q  <= PH_RECOV;
                  cnt_q <= rec_q - TCNT_W'(1);
               end else begin
                  cnt_q <= cnt_q - TCNT_W'(1);
               end
            end
            default: begin
               if (last) ph_q  <= PH_IDLE;
               else      cnt_q <= cnt_q - TCNT_W'(1);
            end
         endcase
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cs
      assign cs[c] = (ph_q == PH_SETUP || ph_q == PH_ACTIVE) && (chan_q == CH_W'(c));
   end

   assign ready     = (ph_q == PH_IDLE);
   assign rd_strobe = (ph_q == PH_ACTIVE) && !wr_q;
   assign wr_strobe = (ph_q == PH_ACTIVE) &&  wr_q;
   assign done      = (ph_q == PH_RECOV) && last;

endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer
   import pio_tmg_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int RESET_REV = 1,
   parameter bit REV_EXTRA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_setup_only,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              req_valid,
   input  logic [1:0]        req_drive,
   input  logic              req_cmd,
   input  logic              req_write,
   output logic              req_ready,
   output logic [1:0]        cs,
   output logic              rd_strobe,
   output logic              wr_strobe,
   output logic              done
);

   localparam int NUM_CH   = 2;
   localparam int NUM_SETS = NUM_CH + 1;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end

   logic [1:0]                 cfg_rev;
   logic [BYTE_W-1:0]          cmd_tmg;
   logic [NUM_SETS*BYTE_W-1:0] addr_tmg;
   logic [NUM_SETS*BYTE_W-1:0] rw_tmg;
   tmg_t                       tmg;

   pio_tmg_regs #(
      .ADDR_W   (ADDR_W),
      .NUM_SETS (NUM_SETS),
      .RESET_REV(RESET_REV)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .setup_only(reg_setup_only),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .cfg_rev   (cfg_rev),
      .cmd_tmg   (cmd_tmg),
      .addr_tmg  (addr_tmg),
      .rw_tmg    (rw_tmg)
   );

   pio_tmg_resolve #(
      .NUM_SETS (NUM_SETS),
      .REV_EXTRA(REV_EXTRA)
   ) u_resolve (
      .drive   (req_drive),
      .is_cmd  (req_cmd),
      .cfg_rev (cfg_rev),
      .cmd_tmg (cmd_tmg),
      .addr_tmg(addr_tmg),
      .rw_tmg  (rw_tmg),
      .tmg     (tmg)
   );

   pio_tmg_seq #(
      .NUM_CH(NUM_CH)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_chan (req_drive[1]),
      .req_write(req_write),
      .tmg      (tmg),
      .ready    (req_ready),
      .cs       (cs),
      .rd_strobe(rd_strobe),
      .wr_strobe(wr_strobe),
      .done     (done)
   );

endmodule

// File: rtl/pio_tmg_chk.sv
module pio_tmg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [1:0] cs,
   input logic       rd_strobe,
   input logic       wr_strobe,
   input logic       done
);

   // R8: the two strobes never overlap
   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_strobe && wr_strobe));

   // R6: at most one channel selected
   p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));

   // R8: a strobe is always inside chip-select
   p_strobe_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe || wr_strobe) |-> (cs != 2'b00));

   // R8: done lasts a single clock
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: idle follows done
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);

   // R8: nothing is driven on the bus while idle
   p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs == 2'b00 && !rd_strobe && !wr_strobe && !done));

   // R8: an accepted request leaves idle
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);

   // R4: the active phase is at least two clocks
   p_active_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_strobe || wr_strobe) |-> $past(rd_strobe || wr_strobe, 2));

   // R2: setup is at least two clocks of chip-select before the strobe
   p_setup_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_strobe || wr_strobe) |-> ($past(cs != 2'b00, 1) && $past(cs != 2'b00, 2)));

endmodule

bind ide_strobe_timer pio_tmg_chk u_chk (.*);

// File: tb/tb_ide_strobe_timer.sv
`timescale 1ns/1ps
module tb_ide_strobe_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_setup_only = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       req_valid = 1'b0;
   logic [1:0] req_drive = '0;
   logic       req_cmd = 1'b0;
   logic       req_write = 1'b0;
   logic       req_ready;
   logic [1:0] cs;
   logic       rd_strobe;
   logic       wr_strobe;
   logic       done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   int m_s, m_a, m_r, m_bad;

   always #2.5 clk = ~clk;

   ide_strobe_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_setup_only(reg_setup_only),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_drive(req_drive), .req_cmd(req_cmd),
      .req_write(req_write), .req_ready(req_ready), .cs(cs),
      .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .done(done)
   );

   function automatic int exp_setup(input int code);
      case (code)
         0: return 4;
         2: return 3;
         1: return 2;
         default: return 5;
      endcase
   endfunction
   function automatic int exp_act(input int n);
      return (n == 0) ? 16 : ((n == 1) ? 2 : n);
   endfunction
   function automatic int exp_rec(input int n, input int rev);
      return ((n == 0) ? 16 : n) + ((rev > 1) ? 1 : 0);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wreg(input int a, input int d, input bit so);
      reg_we = 1'b1; reg_setup_only = so; reg_addr = 3'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0; reg_setup_only = 1'b0;
   endtask

   task automatic rreg(input string tag, input int a, input int exp);
      reg_addr = 3'(a);
      #1;
      chk(tag, int'(reg_rdata), exp);
   endtask

   // issues one request at a negedge where the block is idle, measures phases
   task automatic run_cyc(input int d, input bit c, input bit w,
                          input bit inj_req, input bit inj_wr, input int wa, input int wd);
      logic [1:0] exp_cs;
      exp_cs = (d >= 2) ? 2'b10 : 2'b01;
      m_s = 0; m_a = 0; m_r = 0; m_bad = 0;
      req_valid = 1'b1; req_drive = 2'(d); req_cmd = c; req_write = w;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 80; k++) begin
         if (inj_req && k == 2) begin
            req_valid = 1'b1; req_drive = ~2'(d); req_cmd = 1'b0; req_write = ~w;
         end
         if (inj_wr && k == 1) begin
            reg_we = 1'b1; reg_addr = 3'(wa); reg_wdata = 8'(wd);
         end
         if (inj_wr && k == 2) reg_we = 1'b0;
         if (rd_strobe || wr_strobe) begin
            m_a++;
            if (cs != exp_cs || rd_strobe != !w || wr_strobe != w || m_r != 0) m_bad++;
         end else if (cs != 2'b00) begin
            m_s++;
            if (cs != exp_cs || m_a != 0) m_bad++;
         end else begin
            m_r++;
         end
         if (req_ready) m_bad++;
         if (done) break;
         @(negedge clk);
      end
      req_valid = 1'b0; reg_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_cyc(input string tag, input int s, input int a, input int r);
      chk({tag, " R2 setup"}, m_s, s);
      chk({tag, " R4 active"}, m_a, a);
      chk({tag, " R5 recovery"}, m_r, r);
      chk({tag, " R8 phase order/pins"}, m_bad, 0);
      chk({tag, " R8 ready after done"}, int'(req_ready), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int rev;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ready", int'(req_ready), 1);
      chk("R1 cs", int'(cs), 0);
      chk("R1 strobes", int'({rd_strobe, wr_strobe, done}), 0);
      rreg("R1 cfg", 0, 1);
      for (int a = 1; a < 8; a++) rreg("R1 reg", a, 0);
      run_cyc(0, 0, 0, 0, 0, 0, 0);
      expect_cyc("R1 default", 4, 16, 16);

      // R10 readback
      wreg(1, 8'hA5, 0); rreg("R10 cmd", 1, 8'hA5);
      wreg(0, 8'hFE, 0); rreg("R10 cfg", 0, 8'h02);
      wreg(5, 8'h3C, 0); rreg("R10 rw1", 5, 8'h3C);
      wreg(1, 0, 0); wreg(0, 1, 0); wreg(5, 0, 0);

      // R2 R4 R5 sweep across drives and revisions
      for (int rv = 1; rv <= 2; rv++) begin
         rev = rv;
         wreg(0, rev, 0);
         for (int d = 0; d < 4; d++) begin
            int su_a;
            int rw_a;
            su_a = 2 + 2 * ((d < 2) ? d : 2);
            rw_a = su_a + 1;
            wreg(rw_a, 8'h23, 0);
            for (int code = 0; code < 4; code++) begin
               wreg(su_a, (code << 6) | 8'h15, 0);
               run_cyc(d, 0, code[0], 0, 0, 0, 0);
               expect_cyc("R2 sweep", exp_setup(code), 2, exp_rec(3, rev));
            end
            wreg(su_a, 8'h80, 0);
            for (int n = 0; n < 16; n++) begin
               wreg(rw_a, (n << 4) | 3, 0);
               run_cyc(d, 0, n[0], 0, 0, 0, 0);
               expect_cyc("R4 sweep", 3, exp_act(n), exp_rec(3, rev));
            end
            for (int n = 0; n < 16; n++) begin
               wreg(rw_a, 8'h20 | n, 0);
               run_cyc(d, 0, n[0], 0, 0, 0, 0);
               expect_cyc("R5 sweep", 3, 2, exp_rec(n, rev));
            end
            wreg(su_a, 0, 0); wreg(rw_a, 0, 0);
         end
      end
      wreg(0, 1, 0);

      // R6 shared secondary set, private primary sets
      wreg(6, 8'h40, 0); wreg(7, 8'h54, 0);
      run_cyc(2, 0, 0, 0, 0, 0, 0); expect_cyc("R6 drive2", 2, 5, 4);
      run_cyc(3, 0, 1, 0, 0, 0, 0); expect_cyc("R6 drive3", 2, 5, 4);
      wreg(2, 8'hC0, 0); wreg(3, 8'h22, 0);
      run_cyc(1, 0, 0, 0, 0, 0, 0); expect_cyc("R6 drive1 untouched", 4, 16, 16);
      run_cyc(0, 0, 0, 0, 0, 0, 0); expect_cyc("R6 drive0", 5, 2, 2);

      // R7 command timing
      run_cyc(0, 1, 1, 0, 0, 0, 0); expect_cyc("R7 cmd zero", 4, 16, 16);
      wreg(0, 3, 0);
      run_cyc(2, 1, 0, 0, 0, 0, 0); expect_cyc("R7 cmd zero rev3", 4, 16, 17);
      wreg(0, 1, 0);
      wreg(1, 8'h35, 0);
      run_cyc(0, 1, 0, 0, 0, 0, 0); expect_cyc("R7 cmd nonzero", 5, 3, 5);
      run_cyc(0, 0, 0, 0, 0, 0, 0); expect_cyc("R7 data ignores cmd", 5, 2, 2);
      wreg(1, 0, 0);

      // R3 setup-only write
      wreg(4, 8'h2A, 0);
      wreg(4, 8'hC0, 1); rreg("R3 keep low bits", 4, 8'hEA);
      wreg(5, 8'h99, 1); rreg("R3 no effect on strobe byte", 5, 0);
      run_cyc(1, 0, 0, 0, 0, 0, 0); expect_cyc("R3 code applied", 5, 16, 16);

      // R8 requests while busy are ignored
      run_cyc(0, 0, 0, 1, 0, 0, 0); expect_cyc("R8 busy req", 5, 2, 2);
      for (int k = 0; k < 3; k++) begin
         chk("R8 ignored req no cs", int'(cs), 0);
         chk("R8 ignored req ready", int'(req_ready), 1);
         @(negedge clk);
      end

      // R9 write during a cycle
      run_cyc(0, 0, 1, 0, 1, 3, 8'h55); expect_cyc("R9 current cycle", 5, 2, 2);
      run_cyc(0, 0, 1, 0, 0, 0, 0);     expect_cyc("R9 next cycle", 5, 5, 5);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule